// File: doc/BRIEF.md
# Ultrasonic range frame receiver

This block listens to the serial output of an ultrasonic ranging receiver and recovers each distance reading from it. The sensor sends 8N1 characters at 115200 baud, about fifty packets a second. Each packet is a header byte of 0xA5 followed by a 16-bit distance in millimetres, high byte first. The block contains its own oversampling UART receiver, a byte-level packet parser that finds the header, and a watchdog that reports when the readings stop arriving.

Each completed packet is presented on `dist_mm` with a one-clock `dist_valid` strobe. This output stream has no ready input. The sensor cannot be paused, so no back-pressure is possible: a consumer must capture `dist_mm` on the strobe cycle, or read it later, because it holds until the next complete packet. The block counts bad characters, detected by a low stop bit, on `err_count`. It raises `stale` when the packet stream has gone quiet.

Top module: `range_frame_rx`

## Requirements
- R1: While reset is high, and in the cycle after it, `dist_mm` is 0, `dist_valid` is 0, `stale` is 0 and `err_count` is 0.
- R2: Characters are 8N1: a low start bit, eight data bits least significant first, then a high stop bit, at BAUD. Each bit is sampled 16 times. The bit value is the majority of samples 7, 8 and 9, so a glitch no wider than one sample period inside a bit does not change the received byte.
- R3: The byte sequence 0xA5, H, L produces `dist_mm` = {H, L}, so 0xA5 0x55 0x11 gives 0x5511. The new value appears together with a `dist_valid` pulse, once the stop bit of L has been sampled. `dist_mm` holds its value between pulses.
- R4: While no packet is in progress, any byte other than 0xA5 is dropped without output. The parser realigns on the next 0xA5.
- R5: Once a header has been accepted, the next two bytes are taken as distance data even if either of them is 0xA5.
- R6: A character whose stop bit samples low is discarded. `err_count` increments by one, saturating at its maximum, and the parser returns to header search. Any partial packet is lost.
- R7: If the line stays idle for more than one character time (160 sample periods) after the header or high byte, the partial packet is abandoned and produces no output. Shorter gaps are tolerated.
- R8: `stale` rises after STALE_US microseconds with no complete packet. It falls in the cycle after the next `dist_valid` pulse.
- R9: `dist_valid` is never high for two consecutive cycles, and each complete packet gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_HZ) |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial line from the sensor, idle high, asynchronous |
| dist_mm | output | 16 | Last complete distance reading in millimetres |
| dist_valid | output | 1 | One-cycle strobe marking a new `dist_mm` |
| stale | output | 1 | No complete packet received within STALE_US |
| err_count | output | ERR_W | Saturating count of characters with a low stop bit |

## Verification
The parser is driven with well-formed packets carrying random distance bytes. These are interleaved with runs of random non-header bytes, which separate correct realignment from acceptance of garbage. Packets whose data bytes equal the header value show that the parser tracks its position in the packet rather than searching for the header again. A short glitch placed at a bit centre tests the majority vote. A corrupted stop bit, a long mid-packet pause set against a short one, and a silent interval longer than the stale window each exercise a path that must discard data or change a flag without producing a spurious reading.

// File: rtl/range_rx_pkg.sv
package range_rx_pkg;

  typedef enum logic {
    RX_IDLE,
    RX_RUN
  } rx_state_t;

  typedef enum logic [1:0] {
    PS_HUNT,
    PS_HIGH,
    PS_LOW
  } parse_state_t;

  // Number of bit slots in one 8N1 character: start, eight data bits, stop.
  localparam int CHAR_BITS = 10;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV = 27
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == W'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_byte_core.sv
module rx_byte_core
  import range_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_in,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       frame_err,
  output logic       busy
);
  localparam int PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] S_A = PH_W'(OSR / 2 - 1);
  localparam logic [PH_W-1:0] S_B = PH_W'(OSR / 2);
  localparam logic [PH_W-1:0] S_C = PH_W'(OSR / 2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [3:0] STOP_SLOT = 4'(CHAR_BITS - 1);

  logic [SYNC-1:0] sync_q;
  logic            line_s;
  logic            prev;
  rx_state_t       state;
  logic [PH_W-1:0] ph;
  logic [3:0]      slot;
  logic            samp_a, samp_b;
  logic [7:0]      shreg;
  logic            bitv;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], line_in};
  end
  assign line_s = sync_q[SYNC-1];
  assign bitv   = vote3(samp_a, samp_b, line_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      prev      <= 1'b1;
      ph        <= '0;
      slot      <= '0;
      samp_a    <= 1'b1;
      samp_b    <= 1'b1;
      shreg     <= '0;
      byte_stb  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_stb  <= 1'b0;
      frame_err <= 1'b0;
      if (tick) begin
        prev <= line_s;
        if (state == RX_IDLE) begin
          if (prev && !line_s) begin
            state <= RX_RUN;
            ph    <= PH_W'(1);
            slot  <= '0;
          end
        end else begin
          if (ph == PH_LAST) begin
            ph   <= '0;
            slot <= slot + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
          if (ph == S_A) samp_a <= line_s;
          if (ph == S_B) samp_b <= line_s;
          if (ph == S_C) begin
            if (slot == 4'd0) begin
              if (bitv) state <= RX_IDLE;
            end else if (slot == STOP_SLOT) begin
              state <= RX_IDLE;
              if (bitv) byte_stb  <= 1'b1;
              else      frame_err <= 1'b1;
            end else begin
              shreg <= {bitv, shreg[7:1]};
            end
          end
        end
      end
    end
  end

  assign byte_data = shreg;
  assign busy      = (state == RX_RUN);
endmodule

// File: rtl/range_parser.sv
module range_parser
  import range_rx_pkg::*;
#(
  parameter logic [7:0] HDR        = 8'hA5,
  parameter int          GAP_TICKS  = 160,
  parameter int          ERR_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             byte_stb,
  input  logic [7:0]       byte_data,
  input  logic             frame_err,
  input  logic             busy,
  output logic [15:0]      dist_mm,
  output logic             dist_valid,
  output logic [ERR_W-1:0] err_count
);
  localparam int GW = $clog2(GAP_TICKS + 1);

  parse_state_t st;
  logic [7:0]   hi_q;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PS_HUNT;
      hi_q       <= '0;
      gap        <= '0;
      dist_mm    <= '0;
      dist_valid <= 1'b0;
      err_count  <= '0;
    end else begin
      dist_valid <= 1'b0;
      if (st == PS_HUNT || busy || byte_stb) gap <= '0;
      else if (tick)                         gap <= gap + 1'b1;

      if (frame_err) begin
        st <= PS_HUNT;
        if (err_count != '1) err_count <= err_count + 1'b1;
      end else if (byte_stb) begin
        unique case (st)
          PS_HUNT: if (byte_data == HDR) st <= PS_HIGH;
          PS_HIGH: begin
            hi_q <= byte_data;
            st   <= PS_LOW;
          end
          PS_LOW: begin
            dist_mm    <= {hi_q, byte_data};
            dist_valid <= 1'b1;
            st         <= PS_HUNT;
          end
          default: st <= PS_HUNT;
        endcase
      end else if (tick && st != PS_HUNT && !busy && gap == GW'(GAP_TICKS)) begin
        st <= PS_HUNT;
      end
    end
  end
endmodule

// File: rtl/stale_watch.sv
module stale_watch #(
  parameter int CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pkt,
  output logic stale
);
  localparam int W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      stale <= 1'b0;
    end else if (pkt) begin
      cnt   <= '0;
      stale <= 1'b0;
    end else if (cnt == W'(CYCLES - 1)) begin
      stale <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/range_frame_rx.sv
module range_frame_rx
  import range_rx_pkg::*;
#(
  parameter int          CLK_HZ   = 50_000_000,
  parameter int          BAUD     = 115_200,
  parameter int          OSR      = 16,
  parameter logic [7:0]  HDR      = 8'hA5,
  parameter int          STALE_US = 100_000,
  parameter int          ERR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_line,
  output logic [15:0]      dist_mm,
  output logic             dist_valid,
  output logic             stale,
  output logic [ERR_W-1:0] err_count
);
  localparam int TICK_DIV     = CLK_HZ / (BAUD * OSR);
  localparam int GAP_TICKS    = CHAR_BITS * OSR;
  localparam int STALE_CYCLES = (CLK_HZ / 1_000_000) * STALE_US;

  logic       tick;
  logic       byte_stb;
  logic [7:0] byte_data;
  logic       frame_err;
  logic       busy;

  rx_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rx_byte_core #(.OSR(OSR), .SYNC(2)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .line_in   (rx_line),
    .byte_stb  (byte_stb),
    .byte_data (byte_data),
    .frame_err (frame_err),
    .busy      (busy)
  );

  range_parser #(.HDR(HDR), .GAP_TICKS(GAP_TICKS), .ERR_W(ERR_W)) u_parse (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .byte_stb   (byte_stb),
    .byte_data  (byte_data),
    .frame_err  (frame_err),
    .busy       (busy),
    .dist_mm    (dist_mm),
    .dist_valid (dist_valid),
    .err_count  (err_count)
  );

  stale_watch #(.CYCLES(STALE_CYCLES)) u_stale (
    .clk   (clk),
    .rst   (rst),
    .pkt   (dist_valid),
    .stale (stale)
  );
endmodule

// File: rtl/range_frame_rx_chk.sv
module range_frame_rx_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [15:0]      dist_mm,
  input logic             dist_valid,
  input logic             stale,
  input logic [ERR_W-1:0] err_count
);
  // R1: outputs are cleared in the cycle after reset is sampled
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dist_mm == '0 && !dist_valid && !stale && err_count == '0));

  // R9: the strobe lasts exactly one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dist_valid |=> !dist_valid);

  // R3: the reading only moves together with the strobe
  a_r3_hold_value: assert property (@(posedge clk) disable iff (rst)
    !dist_valid |-> $stable(dist_mm));

  // R6: the error count only ever steps up by one
  a_r6_err_step: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) |-> (err_count == ERR_W'($past(err_count) + 1'b1)));

  // R8: a fresh packet clears the stale flag on the next cycle
  a_r8_stale_clear: assert property (@(posedge clk) disable iff (rst)
    dist_valid |=> !stale);
endmodule

bind range_frame_rx range_frame_rx_chk #(.ERR_W(ERR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dist_mm    (dist_mm),
  .dist_valid (dist_valid),
  .stale      (stale),
  .err_count  (err_count)
);

// File: tb/range_frame_rx_bench.sv
`timescale 1ns / 1ps
module range_frame_rx_bench;
  localparam int CLK_HZ   = 50_000_000;
  localparam int BAUD     = 1_562_500;  // two clocks per sample tick
  localparam int OSR      = 16;
  localparam int BIT_CLK  = CLK_HZ / BAUD;
  localparam int STALE_US = 40;
  localparam int STALE_CY = (CLK_HZ / 1_000_000) * STALE_US;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic [15:0] dist_mm;
  logic        dist_valid;
  logic        stale;
  logic [7:0]  err_count;

  int n_chk  = 0;
  int n_fail = 0;
  int got_n  = 0;
  logic [15:0] got_last = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  range_frame_rx #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .OSR(OSR), .HDR(8'hA5),
    .STALE_US(STALE_US), .ERR_W(8)
  ) u_range_frame_rx (
    .clk(clk), .rst(rst), .rx_line(rx_line),
    .dist_mm(dist_mm), .dist_valid(dist_valid),
    .stale(stale), .err_count(err_count)
  );

  always @(negedge clk) begin
    if (!rst && dist_valid) begin
      got_n    = got_n + 1;
      got_last = dist_mm;
    end
  end

  function automatic logic [15:0] exp_dist(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_hi, input int glitch_bit);
    rx_line = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = b[i];
      if (glitch_bit == i) begin
        repeat (BIT_CLK / 2 + 2) @(negedge clk);
        rx_line = ~b[i];
        repeat (2) @(negedge clk);
        rx_line = b[i];
        repeat (BIT_CLK / 2 - 4) @(negedge clk);
      end else begin
        repeat (BIT_CLK) @(negedge clk);
      end
    end
    rx_line = stop_hi;
    repeat (BIT_CLK) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic send_pkt(input logic [7:0] hi, input logic [7:0] lo);
    send_byte(8'hA5, 1'b1, -1);
    send_byte(hi, 1'b1, -1);
    send_byte(lo, 1'b1, -1);
    idle(8);
  endtask

  task automatic expect_one(input string req, input int n0, input logic [15:0] exp);
    check(got_n == n0 + 1, req, got_n - n0, 1);
    check(got_last == exp && dist_mm == exp, req, got_last, exp);
  endtask

  initial begin
    repeat (190_000) @(negedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [7:0] hi, lo, g;
    void'($urandom(32'd6813));
    repeat (6) @(negedge clk);
    // R1: reset state, sampled while reset is still high
    check(dist_mm == 16'h0 && !dist_valid, "R1", dist_mm, 0);
    check(!stale && err_count == 8'd0, "R1", {stale, err_count}, 0);
    rst = 1'b0;
    idle(20);
    check(!stale && err_count == 8'd0 && dist_mm == 16'h0, "R1", dist_mm, 0);

    // R3: directed packet
    n0 = got_n;
    send_pkt(8'h55, 8'h11);
    expect_one("R3", n0, 16'h5511);

    // R3 / R9: random packets, each gives one reading
    for (int k = 0; k < 6; k++) begin
      hi = 8'($urandom_range(0, 255));
      lo = 8'($urandom_range(0, 255));
      n0 = got_n;
      send_pkt(hi, lo);
      expect_one("R9", n0, exp_dist(hi, lo));
    end
    // R3: value holds with no traffic
    idle(300);
    check(dist_mm == got_last, "R3", dist_mm, got_last);

    // R4: random non-header garbage, then a packet
    n0 = got_n;
    for (int k = 0; k < 4; k++) begin
      g = 8'($urandom_range(0, 255));
      if (g == 8'hA5) g = 8'h5A;
      send_byte(g, 1'b1, -1);
    end
    check(got_n == n0, "R4", got_n - n0, 0);
    send_pkt(8'h03, 8'hE8);
    expect_one("R4", n0, 16'h03E8);

    // R5: header value inside the data bytes
    n0 = got_n;
    send_pkt(8'hA5, 8'hA5);
    expect_one("R5", n0, 16'hA5A5);
    n0 = got_n;
    send_pkt(8'h12, 8'hA5);
    expect_one("R5", n0, 16'h12A5);

    // R2: one-sample glitch at a bit centre is voted out
    n0 = got_n;
    send_byte(8'hA5, 1'b1, -1);
    send_byte(8'h6C, 1'b1, 2);
    send_byte(8'h39, 1'b1, 5);
    idle(8);
    expect_one("R2", n0, 16'h6C39);

    // R6: low stop bit drops the packet and counts one error
    n0 = got_n;
    send_byte(8'hA5, 1'b1, -1);
    send_byte(8'h22, 1'b0, -1);
    idle(40);
    send_byte(8'h33, 1'b1, -1);
    idle(8);
    check(got_n == n0, "R6", got_n - n0, 0);
    check(err_count == 8'd1, "R6", err_count, 1);
    send_pkt(8'h01, 8'h02);
    expect_one("R6", n0, 16'h0102);
    check(err_count == 8'd1, "R6", err_count, 1);

    // R7: a long pause mid-packet abandons it
    n0 = got_n;
    send_byte(8'hA5, 1'b1, -1);
    send_byte(8'h44, 1'b1, -1);
    idle(3 * 10 * BIT_CLK);
    send_byte(8'h66, 1'b1, -1);
    idle(8);
    check(got_n == n0, "R7", got_n - n0, 0);
    // R7: a short pause is tolerated
    send_byte(8'hA5, 1'b1, -1);
    idle(100);
    send_byte(8'h07, 1'b1, -1);
    idle(100);
    send_byte(8'hD0, 1'b1, -1);
    idle(8);
    expect_one("R7", n0, 16'h07D0);

    // R8: stale after the window, cleared by the next packet
    send_pkt(8'h0A, 8'h0B);
    check(!stale, "R8", stale, 0);
    idle(STALE_CY * 3 / 4);
    check(!stale, "R8", stale, 0);
    idle(STALE_CY / 2);
    check(stale, "R8", stale, 1);
    n0 = got_n;
    send_pkt(8'h0C, 8'h0D);
    expect_one("R8", n0, 16'h0C0D);
    check(!stale, "R8", stale, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule